// File: doc/BRIEF.md
# Tagged Page-Buffer Controller for On-Chip Non-Volatile Data Memory

This block sits in front of a small non-volatile data store, held here as a register array, and stages every change through a one-page buffer. Each buffer byte carries a tag bit. A load command merges one byte into the buffer by bitwise AND and sets that byte's tag. A buffer-erase command returns the buffer to all ones and drops every tag. The buffer therefore has to be erased before a location is loaded, because a second load of the same location without an erase in between merges the two values.

Three page commands act on one chosen page: erase, write, and atomic erase-then-write. Each touches only the tagged offsets of that page. Untagged offsets and all other pages keep their stored values. An erase ignores the buffered data and looks only at the tags. Each page command holds `busy` for a programmed number of cycles, however many bytes are tagged. It then pulses `done`, clears every tag and refills the buffer with ones. Any command that arrives while `busy` is high is refused, and `err` pulses.

Top module: `nvm_pagebuf_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `rd_valid` are low, the buffer holds all ones with no tags set, and every memory byte reads 0xFF.
- R2: A load (cmd_op 1) writes the AND of the buffer byte at offset cmd_addr[3:0] and cmd_wdata into that byte and sets its tag. The page bits of the address are not used.
- R3: Two loads to the same offset with no buffer erase in between leave the AND of both data values in the buffer.
- R4: A buffer erase (cmd_op 2) sets every buffer byte to 0xFF and clears every tag, so bytes loaded before it are not applied by a later page command.
- R5: A page erase (cmd_op 3) sets each tagged byte of the target page to 0xFF, whatever data the buffer holds there. The target page is cmd_addr[6:4].
- R6: A page write (cmd_op 4) replaces each tagged byte of the target page with the AND of its stored value and the buffer byte.
- R7: An atomic erase-and-write (cmd_op 5) replaces each tagged byte of the target page with the buffer byte.
- R8: Untagged bytes of the target page, and every byte of the other pages, keep their values through any page command.
- R9: A page command sampled at a clock edge holds `busy` high for exactly `op_cycles` cycles, or for one cycle when `op_cycles` is 0. This does not depend on how many bytes are tagged. `done` is high for the single cycle after `busy` falls, and the memory shows the new contents in that same cycle.
- R10: When a page command completes, all tags are cleared and the buffer returns to 0xFF.
- R11: Any non-zero cmd_op presented while `busy` is high has no effect and pulses `err` high for one cycle in the next cycle. Codes 0 and 7 do nothing at any time.
- R12: A read (cmd_op 6) returns the memory byte at cmd_addr on `rd_data`, with `rd_valid` high for one cycle, one cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code: 0 none, 1 load, 2 buffer erase, 3 page erase, 4 page write, 5 atomic erase-write, 6 read |
| cmd_addr | input | 7 | Byte address: page in the upper bits, offset in the lower four |
| cmd_wdata | input | 8 | Data for a load |
| op_cycles | input | 8 | Busy length of a page command in cycles, sampled when the command starts |
| busy | output | 1 | A page command is in progress |
| done | output | 1 | One-cycle pulse when a page command ends |
| err | output | 1 | One-cycle pulse after a refused command |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |

## Verification
A load or buffer erase changes the buffer at the edge that samples it. Its effect becomes visible only through a later page command and a read-back. A read answers one edge after it is sampled. `err` follows one edge after a refused command. A page command raises `busy` at the sampling edge, and the bench counts `busy` at each falling clock edge until it drops. At that same falling edge the bench requires `done` high and compares the count with the programmed length, then requires `done` low one cycle later. Reads are issued only after `done`, and every returned byte is compared with a page model that the bench updates from its own copy of the buffer and tags.

// File: rtl/nvm_pb_pkg.sv
package nvm_pb_pkg;
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_LOAD      = 3'd1,
    OP_BUF_ERASE = 3'd2,
    OP_PG_ERASE  = 3'd3,
    OP_PG_WRITE  = 3'd4,
    OP_PG_ERWR   = 3'd5,
    OP_READ      = 3'd6,
    OP_RSVD      = 3'd7
  } nvm_op_e;
endpackage

// File: rtl/nvm_pb_buffer.sv
module nvm_pb_buffer
  import nvm_pb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   load_en,
  input  logic [OFF_W-1:0]                       load_off,
  input  logic [DATA_W-1:0]                      load_data,
  input  logic                                   clear,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]      buf_q,
  output logic [PAGE_BYTES-1:0]                  tag_q
);

  // Loads merge by AND; a clear restores the erased (all ones) state.
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      buf_q <= '1;
      tag_q <= '0;
    end else if (load_en) begin
      buf_q[load_off] <= buf_q[load_off] & load_data;
      tag_q[load_off] <= 1'b1;
    end
  end

  // R2: a load leaves its offset tagged
  assert_load_tags_R2: assert property (@(posedge clk) disable iff (rst)
    (load_en && !clear) |=> tag_q[$past(load_off)]);

  // R3: a load never sets a bit that was clear in the buffer
  assert_and_merge_R3: assert property (@(posedge clk) disable iff (rst)
    (load_en && !clear) |=> ((buf_q[$past(load_off)] & ~$past(buf_q[load_off])) == '0));

  // R10: after a clear, no tag survives
  assert_clear_tags_R10: assert property (@(posedge clk) disable iff (rst)
    clear |=> (tag_q == '0));

endmodule

// File: rtl/nvm_pb_sequencer.sv
module nvm_pb_sequencer
  import nvm_pb_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int CYC_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  nvm_op_e           start_op,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [CYC_W-1:0]  op_cycles,
  output logic              busy,
  output logic              done,
  output logic              apply,
  output nvm_op_e           act_op,
  output logic [PAGE_W-1:0] act_page
);

  logic [CYC_W-1:0] cnt_q;

  // The last busy cycle commits the page.
  assign apply = busy && (cnt_q == CYC_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt_q    <= '0;
      act_op   <= OP_NOP;
      act_page <= '0;
    end else begin
      done <= apply;
      if (start) begin
        busy     <= 1'b1;
        cnt_q    <= (op_cycles == '0) ? CYC_W'(1) : op_cycles;
        act_op   <= start_op;
        act_page <= start_page;
      end else if (apply) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt_q <= cnt_q - CYC_W'(1);
      end
    end
  end

  // R9: done lasts one cycle
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: done appears exactly as busy drops
  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R11: no new page command is started while one is running
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

endmodule

// File: rtl/nvm_pb_array.sv
module nvm_pb_array
  import nvm_pb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int NUM_PAGES  = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int ADDR_W    = OFF_W + PAGE_W,
  localparam int DEPTH     = PAGE_BYTES * NUM_PAGES
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              apply,
  input  nvm_op_e                           apply_op,
  input  logic [PAGE_W-1:0]                 apply_page,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_data,
  input  logic [PAGE_BYTES-1:0]             buf_tag,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data,
  output logic                              rd_valid
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[rd_addr];
      if (apply) begin
        for (int o = 0; o < PAGE_BYTES; o++) begin
          if (buf_tag[o]) begin
            case (apply_op)
              OP_PG_ERASE: mem[{apply_page, OFF_W'(o)}] <= '1;
              OP_PG_WRITE: mem[{apply_page, OFF_W'(o)}] <=
                             mem[{apply_page, OFF_W'(o)}] & buf_data[o];
              default:     mem[{apply_page, OFF_W'(o)}] <= buf_data[o];
            endcase
          end
        end
      end
    end
  end

  // R12: read data is valid only on the cycle after a read request
  assert_read_latency_R12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  // R11: reads and page commits never overlap
  assert_no_read_in_commit_R11: assert property (@(posedge clk) disable iff (rst)
    !(apply && rd_en));

endmodule

// File: rtl/nvm_pagebuf_ctrl.sv
module nvm_pagebuf_ctrl
  import nvm_pb_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int NUM_PAGES  = 8,
  parameter int CYC_W      = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = $clog2(NUM_PAGES),
  localparam int ADDR_W    = OFF_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [CYC_W-1:0]  op_cycles,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  nvm_op_e op_e;
  logic    accept, load_en, buf_erase, start, rd_en, apply, clear;
  nvm_op_e act_op;
  logic [PAGE_W-1:0]                 act_page;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_q;
  logic [PAGE_BYTES-1:0]             tag_q;

  assign op_e      = nvm_op_e'(cmd_op);
  assign accept    = cmd_valid && !busy;
  assign load_en   = accept && (op_e == OP_LOAD);
  assign buf_erase = accept && (op_e == OP_BUF_ERASE);
  assign rd_en     = accept && (op_e == OP_READ);
  assign start     = accept && ((op_e == OP_PG_ERASE) || (op_e == OP_PG_WRITE) ||
                                (op_e == OP_PG_ERWR));
  assign clear     = buf_erase || apply;

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= cmd_valid && busy && (op_e != OP_NOP) && (op_e != OP_RSVD);
  end

  nvm_pb_buffer #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buffer (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .load_off  (cmd_addr[OFF_W-1:0]),
    .load_data (cmd_wdata),
    .clear     (clear),
    .buf_q     (buf_q),
    .tag_q     (tag_q)
  );

  nvm_pb_sequencer #(.PAGE_W(PAGE_W), .CYC_W(CYC_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_op   (op_e),
    .start_page (cmd_addr[ADDR_W-1:OFF_W]),
    .op_cycles  (op_cycles),
    .busy       (busy),
    .done       (done),
    .apply      (apply),
    .act_op     (act_op),
    .act_page   (act_page)
  );

  nvm_pb_array #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_array (
    .clk        (clk),
    .rst        (rst),
    .apply      (apply),
    .apply_op   (act_op),
    .apply_page (act_page),
    .buf_data   (buf_q),
    .buf_tag    (tag_q),
    .rd_en      (rd_en),
    .rd_addr    (cmd_addr),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  // R11: err only follows a command that met a busy block
  assert_err_when_busy_R11: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(cmd_valid && busy));

  // R12: a read answers on the next cycle
  assert_read_reply_R12: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && (cmd_op == 3'd6)) |=> rd_valid);

endmodule

// File: tb/nvm_pagebuf_ctrl_bench.sv
`timescale 1ns/1ps
module nvm_pagebuf_ctrl_bench;
  localparam int PB = 16;
  localparam int NP = 8;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic [7:0] op_cycles = 8'd1;
  logic busy, done, err, rd_valid;
  logic [7:0] rd_data;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  logic [7:0] mem_m [PB*NP];
  logic [7:0] buf_m [PB];
  bit         tag_m [PB];

  always #2.5 clk = ~clk;

  nvm_pagebuf_ctrl u_nvm_pagebuf_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .op_cycles(op_cycles),
    .busy(busy), .done(done), .err(err), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] next_byte(int op, logic [7:0] m, logic [7:0] b);
    case (op)
      3:       return 8'hFF;
      4:       return m & b;
      default: return b;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < PB; i++) begin buf_m[i] = 8'hFF; tag_m[i] = 0; end
  endtask

  // Drives one command for one cycle; returns at the falling edge after it was sampled.
  task automatic drive(input logic [2:0] op, input int addr, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr[AW-1:0]; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic load(input int off, input logic [7:0] d);
    drive(3'd1, off, d);
    buf_m[off] = buf_m[off] & d;
    tag_m[off] = 1;
  endtask

  task automatic buf_erase();
    drive(3'd2, 0, 8'h00);
    model_clear();
  endtask

  task automatic page_op(input int op, input int page, input int len, input string req);
    int cnt;
    op_cycles = len[7:0];
    drive(op[2:0], page * PB, 8'h00);
    cnt = 0;
    while (busy === 1'b1 && cnt < 300) begin
      cnt++;
      @(negedge clk);
    end
    chk({req, " R9 busy length"}, cnt, (len == 0) ? 1 : len);
    chk({req, " R9 done pulse"}, done, 1);
    for (int o = 0; o < PB; o++)
      if (tag_m[o]) mem_m[page*PB+o] = next_byte(op, mem_m[page*PB+o], buf_m[o]);
    model_clear();
    @(negedge clk);
    chk({req, " R9 done single"}, done, 0);
  endtask

  task automatic rd_chk(input int addr, input string req);
    drive(3'd6, addr, 8'h00);
    chk({req, " R12 rd_valid"}, rd_valid, 1);
    chk({req, " data"}, rd_data, mem_m[addr]);
  endtask

  initial begin
    int p, nl, off, op, len;
    logic [7:0] d;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < PB*NP; i++) mem_m[i] = 8'hFF;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 rd_valid", rd_valid, 0);
    rd_chk(0, "R1 first byte");
    rd_chk(PB*NP-1, "R1 last byte");

    // R2 / R6 / R8: single load, page write
    load(3, 8'h5A);
    page_op(4, 2, 3, "R6 write");
    rd_chk(2*PB+3, "R6 tagged byte");
    rd_chk(2*PB+4, "R8 untagged byte");
    rd_chk(1*PB+3, "R8 other page");

    // R10: no loads after completion, so a write changes nothing; len 0 -> 1 cycle
    page_op(4, 2, 0, "R10 empty write");
    rd_chk(2*PB+3, "R10 tags cleared");

    // R3 / R7: double load merges, atomic replaces
    load(3, 8'hF0);
    load(3, 8'h3C);
    page_op(5, 2, 2, "R7 atomic");
    rd_chk(2*PB+3, "R3 merged value R7");

    // R5: erase ignores data; other tagged-free bytes kept
    load(5, 8'h12);
    page_op(5, 2, 1, "R7 prep");
    load(3, 8'h00);
    page_op(3, 2, 4, "R5 erase");
    rd_chk(2*PB+3, "R5 erased byte");
    rd_chk(2*PB+5, "R5 R8 kept byte");

    // R4: buffer erase drops earlier loads
    load(5, 8'h00);
    buf_erase();
    load(6, 8'hA5);
    page_op(5, 2, 2, "R4 atomic");
    rd_chk(2*PB+5, "R4 dropped load");
    rd_chk(2*PB+6, "R4 later load");

    // R11: commands while busy are refused
    load(7, 8'h0F);
    op_cycles = 8'd10;
    drive(3'd4, 4*PB, 8'h00);
    chk("R11 busy started", busy, 1);
    drive(3'd6, 4*PB+7, 8'h00);
    chk("R11 err pulse", err, 1);
    chk("R11 read refused", rd_valid, 0);
    drive(3'd3, 5*PB, 8'h00);
    chk("R11 err again", err, 1);
    @(negedge clk);
    chk("R11 err single", err, 0);
    begin
      int g = 0;
      while (busy === 1'b1 && g < 300) begin g++; @(negedge clk); end
    end
    chk("R11 done after refused", done, 1);
    mem_m[4*PB+7] = mem_m[4*PB+7] & 8'h0F;
    model_clear();
    repeat (3) begin
      @(negedge clk);
      chk("R11 no restarted op", busy, 0);
    end
    rd_chk(4*PB+7, "R11 original op applied");

    // Random rounds
    for (int r = 0; r < 60; r++) begin
      p = $urandom % NP;
      nl = $urandom % 5;
      for (int k = 0; k < nl; k++) begin
        off = $urandom % PB;
        d = 8'($urandom);
        load(off, d);
      end
      if ($urandom % 6 == 0) buf_erase();
      op = 3 + ($urandom % 3);
      len = $urandom % 6;
      page_op(op, p, len, "R5 R6 R7 random");
      for (int k = 0; k < 3; k++) rd_chk(p*PB + ($urandom % PB), "R8 random page");
      rd_chk($urandom % (PB*NP), "R8 random any");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

endmodule